// File: doc/BRIEF.md
# Programmable Inter-Frame Gap Deferral Timer

This block holds back the transmit path of a half-duplex MAC until the medium has been quiet for a programmed gap. Time is measured in bit times, given to the block as a one-cycle tick. The gap has two parts. During the first part, any carrier on the medium sends the timer back to the start. After the first part, carrier is disregarded and the timer simply runs out the rest of the total gap. Only then does it raise the transmit grant toward a pending request.

Two small registers hold the total gap and the length of its first part. Both lengths are applied in steps of four bit times. The total-gap register can only be written while the controller is stopped. The first-part register can be written while the controller is stopped or suspended. A write at any other time is dropped without a trace. Both registers come out of reset at the standard spacing: 96 bit times in total, of which the first 60 are the part where carrier is watched.

Top module: `ifg_defer_timer`

## Requirements
- R1: After reset, reading register select 0 (total gap) returns 0x60 and reading select 1 (first part) returns 0x3C. `tx_grant` is 0.
- R2: The two least significant bits of both registers are ignored for timing. A read returns the value as it was written, including those bits.
- R3: A write to select 0 takes effect only while `stop` is 1. With `stop` at 0 it is dropped and the old value is kept, whatever `spnd` is.
- R4: A write to select 1 takes effect while `stop` or `spnd` is 1. With both at 0 it is dropped.
- R5: With `bit_tick` high every cycle and `tx_req` held high, `tx_grant` rises at the clock edge numbered G+2 after the medium becomes idle (`crs` and `tx_active` both 0). G is the quantized total gap. Counting starts with the first edge that sees the idle medium.
- R6: If carrier is seen at edge P+1 after the idle start, and P is at most the first-part limit L, the deferral restarts from the end of that carrier.
- R7: Carrier first seen at edge P+1 with P greater than L has no effect. The grant still comes at edge G+2.
- R8: The total gap used is never below 4. The first-part limit is the smaller of the quantized first-part value and G-4.
- R9: `tx_grant` is only high when `tx_req` was high at the previous edge. It falls one edge after `tx_req` falls, and it rises again one edge after `tx_req` returns while the gap is complete.
- R10: Own transmission (`tx_active`) drops the grant at the next edge. The full deferral is then counted again from the end of the transmission.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (hardware or software) |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| crs | input | 1 | Carrier sense from the medium |
| tx_active | input | 1 | Own transmission in progress |
| tx_req | input | 1 | Transmit request |
| stop | input | 1 | Controller stopped; unlocks both registers |
| spnd | input | 1 | Controller suspended; unlocks the first-part register |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 total gap, 1 first part |
| wr_data | input | W | Write data in bit times |
| rd_sel | input | 1 | Read target: 0 total gap, 1 first part |
| rd_data | output | W | Registered read data |
| tx_grant | output | 1 | Registered transmit permission |

## Verification
The bench builds the block with its default parameters: 8-bit registers, a four-bit-time step and the standard reset gap. Because `bit_tick` is held high, each gap becomes an exact cycle count that can be predicted. The table of vectors places a carrier pulse one edge before and one edge after the end of the first part, for the default, quantized, clamped and short-gap settings. This makes the restart-versus-ignore boundary of R6 and R7 visible in the grant latency. Directed tests then cover the lock rules of both registers, request withdrawal, and the restart caused by own transmission.

// File: rtl/ifg_pkg.sv
package ifg_pkg;
  // Deferral phases
  typedef enum logic [1:0] {
    ST_BUSY  = 2'd0,  // medium occupied, count held at zero
    ST_PART1 = 2'd1,  // carrier restarts the count
    ST_PART2 = 2'd2,  // carrier ignored, count runs to total gap
    ST_DONE  = 2'd3   // gap complete, grant may follow request
  } ifg_state_e;

  localparam int unsigned REG_TOTAL = 0;
  localparam int unsigned REG_PART1 = 1;
  localparam int unsigned NUM_REGS  = 2;
endpackage

// File: rtl/ifg_cfg_regs.sv
module ifg_cfg_regs
  import ifg_pkg::*;
#(
  parameter int unsigned W         = 8,
  parameter int unsigned GRAN_BITS = 2,
  parameter logic [W-1:0] TOTAL_RST = W'(96),
  parameter logic [W-1:0] PART1_RST = W'(60)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         stop,
  input  logic         spnd,
  input  logic         wr_en,
  input  logic         wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic         rd_sel,
  output logic [W-1:0] rd_data,
  output logic [W-1:0] total_q,
  output logic [W-1:0] part1_q,
  output logic [W-1:0] total_lim,
  output logic [W-1:0] part1_lim
);
  localparam logic [W-1:0] STEP = W'(1 << GRAN_BITS);
  localparam logic [W-1:0] QMASK = ~(STEP - W'(1));

  logic [W-1:0] regs_q [NUM_REGS];
  logic [NUM_REGS-1:0] unlock;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [W-1:0] RST_V = (i == REG_TOTAL) ? TOTAL_RST : PART1_RST;
    if (i == REG_TOTAL) begin : g_lock_total
      assign unlock[i] = stop;
    end else begin : g_lock_part1
      assign unlock[i] = stop | spnd;
    end
    always_ff @(posedge clk) begin
      if (rst) begin
        regs_q[i] <= RST_V;
      end else if (wr_en && (wr_sel == 1'(i)) && unlock[i]) begin
        regs_q[i] <= wr_data;
      end
    end
  end

  assign total_q = regs_q[REG_TOTAL];
  assign part1_q = regs_q[REG_PART1];

  // Quantize and clamp, then register to keep the counter compare shallow
  logic [W-1:0] tot_q_eff, tot_fl, p1_q_eff, p1_cl;
  always_comb begin
    tot_q_eff = total_q & QMASK;
    tot_fl    = (tot_q_eff < STEP) ? STEP : tot_q_eff;
    p1_q_eff  = part1_q & QMASK;
    p1_cl     = (p1_q_eff > (tot_fl - STEP)) ? (tot_fl - STEP) : p1_q_eff;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      total_lim <= TOTAL_RST & QMASK;
      part1_lim <= PART1_RST & QMASK;
      rd_data   <= '0;
    end else begin
      total_lim <= tot_fl;
      part1_lim <= p1_cl;
      rd_data   <= rd_sel ? part1_q : total_q;
    end
  end
endmodule

// File: rtl/ifg_gap_fsm.sv
module ifg_gap_fsm
  import ifg_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         bit_tick,
  input  logic         crs,
  input  logic         tx_active,
  input  logic         tx_req,
  input  logic [W-1:0] total_lim,
  input  logic [W-1:0] part1_lim,
  output logic         tx_grant
);
  ifg_state_e   st_q, st_d;
  logic [W-1:0] cnt_q, cnt_d, cnt_inc;
  logic         busy;

  assign busy    = crs | tx_active;
  assign cnt_inc = cnt_q + W'(1);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      ST_BUSY: begin
        cnt_d = '0;
        if (!busy) st_d = ST_PART1;
      end
      ST_PART1: begin
        if (busy) begin
          st_d  = ST_BUSY;
          cnt_d = '0;
        end else if (bit_tick) begin
          cnt_d = cnt_inc;
          if (cnt_inc >= part1_lim) st_d = ST_PART2;
        end
      end
      ST_PART2: begin
        if (tx_active) begin
          st_d  = ST_BUSY;
          cnt_d = '0;
        end else if (bit_tick) begin
          cnt_d = cnt_inc;
          if (cnt_inc >= total_lim) st_d = ST_DONE;
        end
      end
      ST_DONE: begin
        if (busy) begin
          st_d  = ST_BUSY;
          cnt_d = '0;
        end
      end
      default: st_d = ST_BUSY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_BUSY;
      cnt_q    <= '0;
      tx_grant <= 1'b0;
    end else begin
      st_q     <= st_d;
      cnt_q    <= cnt_d;
      tx_grant <= (st_q == ST_DONE) && tx_req && !busy;
    end
  end
endmodule

// File: rtl/ifg_defer_timer.sv
module ifg_defer_timer #(
  parameter int unsigned W         = 8,
  parameter int unsigned GRAN_BITS = 2,
  parameter logic [W-1:0] TOTAL_RST = W'(96),
  parameter logic [W-1:0] PART1_RST = W'(60)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         bit_tick,
  input  logic         crs,
  input  logic         tx_active,
  input  logic         tx_req,
  input  logic         stop,
  input  logic         spnd,
  input  logic         wr_en,
  input  logic         wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic         rd_sel,
  output logic [W-1:0] rd_data,
  output logic         tx_grant
);
  logic [W-1:0] total_q, part1_q, total_lim, part1_lim;

  ifg_cfg_regs #(
    .W(W), .GRAN_BITS(GRAN_BITS), .TOTAL_RST(TOTAL_RST), .PART1_RST(PART1_RST)
  ) u_regs (
    .clk(clk), .rst(rst), .stop(stop), .spnd(spnd),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data),
    .total_q(total_q), .part1_q(part1_q),
    .total_lim(total_lim), .part1_lim(part1_lim)
  );

  ifg_gap_fsm #(.W(W)) u_fsm (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .crs(crs),
    .tx_active(tx_active), .tx_req(tx_req),
    .total_lim(total_lim), .part1_lim(part1_lim),
    .tx_grant(tx_grant)
  );
endmodule

// File: rtl/ifg_defer_checker.sv
module ifg_defer_checker #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         stop,
  input logic         spnd,
  input logic         wr_en,
  input logic         wr_sel,
  input logic         tx_req,
  input logic         tx_active,
  input logic         tx_grant,
  input logic [W-1:0] total_q,
  input logic [W-1:0] part1_q
);
  AST_TOTAL_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_sel && !stop) |=> $stable(total_q)); // R3

  AST_PART1_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel && !stop && !spnd) |=> $stable(part1_q)); // R4

  AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    !tx_req |=> !tx_grant); // R9

  AST_GRANT_OFF_OWN_TX: assert property (@(posedge clk) disable iff (rst)
    tx_active |=> !tx_grant); // R10

  AST_NO_GRANT_AFTER_RESET: assert property (@(posedge clk)
    $fell(rst) |-> !tx_grant); // R1
endmodule

bind ifg_defer_timer ifg_defer_checker #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .stop(stop), .spnd(spnd),
  .wr_en(wr_en), .wr_sel(wr_sel), .tx_req(tx_req),
  .tx_active(tx_active), .tx_grant(tx_grant),
  .total_q(total_q), .part1_q(part1_q)
);

// File: tb/tb_ifg_defer_timer.sv
module tb_ifg_defer_timer;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int NV = 13;

  // total, first part, carrier pulse offset (0 = none), expected latency, kind
  // kind: 5 plain, 6 restart, 7 ignored, 8 clamp/floor
  localparam logic [7:0] V_TOT [NV] = '{8'h60, 8'h60, 8'h60, 8'h60, 8'h63, 8'h63,
                                         8'h30, 8'h30, 8'h80, 8'h80, 8'h08, 8'h08, 8'h01};
  localparam logic [7:0] V_P1  [NV] = '{8'h3C, 8'h3C, 8'h3C, 8'h3C, 8'h3F, 8'h3F,
                                         8'h3C, 8'h3C, 8'h20, 8'h20, 8'h04, 8'h04, 8'h00};
  localparam int V_P   [NV] = '{0, 10, 60, 61, 60, 61, 44, 45, 32, 33, 4, 5, 0};
  localparam int V_EXP [NV] = '{98, 109, 159, 98, 159, 98, 95, 50, 163, 130, 15, 10, 6};
  localparam int V_KND [NV] = '{5, 6, 6, 7, 6, 7, 8, 8, 6, 7, 8, 8, 8};

  logic clk = 0, rst = 1, bit_tick = 1, crs = 1, tx_active = 0, tx_req = 0;
  logic stop = 0, spnd = 0, wr_en = 0, wr_sel = 0, rd_sel = 0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] rd_data;
  logic tx_grant;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ifg_defer_timer #(.W(W)) dut (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .crs(crs), .tx_active(tx_active),
    .tx_req(tx_req), .stop(stop), .spnd(spnd), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .tx_grant(tx_grant)
  );

  task automatic chk(input string req, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
    end
  endtask

  task automatic wr(input logic sel, input logic [W-1:0] d);
    wr_en = 1; wr_sel = sel; wr_data = d;
    cyc(1);
    wr_en = 0;
  endtask

  task automatic rd(input logic sel, output int v);
    rd_sel = sel;
    cyc(1);
    v = int'(rd_data);
  endtask

  // Drop carrier, optionally pulse it once at offset p, count edges to grant
  task automatic run_gap(input int p, output int n);
    crs = 0; n = 0;
    for (int k = 0; k < 400; k++) begin
      cyc(1); n++;
      if (tx_grant) break;
      if (p != 0 && n == p) crs = 1;
      if (p != 0 && n == p + 1) crs = 0;
    end
  endtask

  function automatic string kind_tag(input int k);
    case (k)
      6: return "R6";
      7: return "R7";
      8: return "R8";
      default: return "R5";
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int v, n;
    @(negedge clk); cyc(2); rst = 0; cyc(1);
    // R1 reset state
    rd(0, v); chk("R1 total reset", v, 8'h60);
    rd(1, v); chk("R1 part1 reset", v, 8'h3C);
    chk("R1 grant after reset", int'(tx_grant), 0);

    // Vector table
    tx_req = 1;
    for (int i = 0; i < NV; i++) begin
      crs = 1; stop = 1;
      wr(0, V_TOT[i]); wr(1, V_P1[i]);
      stop = 0; cyc(2);
      run_gap(V_P[i], n);
      chk({kind_tag(V_KND[i]), " gap latency"}, n, V_EXP[i]);
      crs = 1; cyc(2);
    end

    // R2 raw readback of quantized value
    stop = 1; wr(0, 8'h63); wr(1, 8'h3F); stop = 0;
    rd(0, v); chk("R2 total readback", v, 8'h63);
    rd(1, v); chk("R2 part1 readback", v, 8'h3F);

    // R3 total locked without stop, even when suspended
    spnd = 1; wr(0, 8'h20); spnd = 0;
    rd(0, v); chk("R3 locked total write dropped", v, 8'h63);
    wr(0, 8'h24);
    rd(0, v); chk("R3 locked total write dropped", v, 8'h63);
    stop = 1; wr(0, 8'h60); stop = 0;
    rd(0, v); chk("R3 total write with stop", v, 8'h60);

    // R4 part1 writable under suspend, locked otherwise
    spnd = 1; wr(1, 8'h3C); spnd = 0;
    rd(1, v); chk("R4 part1 write with spnd", v, 8'h3C);
    wr(1, 8'h10);
    rd(1, v); chk("R4 locked part1 write dropped", v, 8'h3C);
    cyc(2);
    run_gap(0, n); chk("R5 default latency", n, 98);

    // R9 grant follows request
    tx_req = 0; cyc(1); chk("R9 grant falls after request drop", int'(tx_grant), 0);
    tx_req = 1; cyc(1); chk("R9 grant returns with request", int'(tx_grant), 1);
    crs = 1; tx_req = 0; cyc(2);
    crs = 0; cyc(120); chk("R9 no grant without request", int'(tx_grant), 0);
    tx_req = 1; cyc(1); chk("R9 grant one edge after request", int'(tx_grant), 1);

    // R10 own transmission
    tx_active = 1; cyc(1); chk("R10 grant drops on own tx", int'(tx_grant), 0);
    cyc(4);
    tx_active = 0; n = 0;
    for (int k = 0; k < 400; k++) begin
      cyc(1); n++;
      if (tx_grant) break;
    end
    chk("R10 deferral after own tx", n, 98);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule